// File: doc/BRIEF.md
# Sixteen-bit free-running timer with compare and capture

This peripheral keeps a 16-bit up-counter that advances on a prescaled tick taken from the system clock, or on rising edges of an external clock pin. Two compare registers watch the counter. A match sets a sticky flag and drives an output pin to a programmed level. Compare A can also restart the counter from zero, which turns the block into a periodic tick source. A capture register takes a snapshot of the counter on a chosen edge of a capture pin.

Software reaches the block over a byte-wide register bus. Every 16-bit quantity sits at a pair of addresses, high byte first, and the two bytes pass through one shared holding byte. A write to a high byte only fills the holding byte, and the value is committed when the low byte is written. A read of a high byte copies the low byte into the holding byte, so the following low-byte read returns the same snapshot. Both compare registers sit behind one address pair, and a select bit picks which one is accessed.

An interrupt request is raised for each flag whose enable is set. It carries an 8-bit vector number, and the capture source has priority over the other sources.

Top module: `fr_timer`

## Requirements
- R1: After reset, every readable register reads 0x00, both compare pins are low and `irqReq` is low.
- R2: The counter sits at address 4 (high byte) and address 5 (low byte). A write to address 4 changes nothing by itself. A following write to address 5 loads the counter with {byte written to 4, byte written to 5}.
- R3: A read of address 4 returns the live high byte and holds the live low byte. A later read of address 5 returns that held byte, even if the counter has moved since.
- R4: Bits 1:0 of the control register (address 0) select the tick. 00 gives one tick per 8 clocks, 01 one per 32 and 10 one per 128. In any window of M times the divisor consecutive clocks, the counter advances by exactly M.
- R5: With bits 1:0 of address 0 set to 11, the counter advances by one for each rising edge of `extClk`.
- R6: The compare registers share addresses 6 (high) and 7 (low). Bit 4 of the output register (address 1) selects compare A when 0 and compare B when 1, for both reads and writes.
- R7: On a tick that finds the counter equal to compare A, bit 3 of the status register (address 3) sets. If status bit 0 is 1, the counter goes to 0 on that tick instead of incrementing.
- R8: A compare-A match drives `cmpOutA` to bit 1 of address 1. A compare-B match drives `cmpOutB` to bit 0 of address 1 and sets status bit 2. Without a match, each pin keeps its level.
- R9: Status flags stay set until software writes 0 to them at address 3. Writing 1 to a flag bit leaves it unchanged.
- R10: A tick that moves the counter from 0xFFFF to 0x0000 sets status bit 1.
- R11: On the `capPin` edge chosen by bit 7 of address 0 (1 for rising, 0 for falling), the counter is copied into the capture register and status bit 7 sets. The capture register reads at addresses 8 and 9 and uses the same holding byte. The opposite edge is ignored.
- R12: The enable register at address 2 uses bits 7, 3, 2 and 1 to enable the flags in the same status bits. `irqReq` is high while any enabled flag is set. `irqVector` shows the capture vector (address 10) while an enabled capture flag is set, and the compare vector (address 11) otherwise.
- R13: With divide-by-128, compare A at 63 and clear-on-match on, the compare-A flag recurs every 8192 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | External count clock, asynchronous |
| capPin | input | 1 | Capture trigger, asynchronous |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe, used only to fill the holding byte |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| cmpOutA | output | 1 | Compare-A output pin |
| cmpOutB | output | 1 | Compare-B output pin |
| irqReq | output | 1 | Interrupt request |
| irqVector | output | 8 | Vector number for the request |

## Verification
Read data is combinational and is sampled one time step after the falling edge. A register write or a holding-byte fill takes effect at the next rising edge, so every bus operation costs exactly one clock. An edge on `extClk` or `capPin` passes two synchronizer stages and one edge detector, so it acts at the third rising edge. The bench holds each pin level for three edges before it reads anything. The prescaler checks place two coherent snapshots exactly M times the divisor edges apart and expect a difference of M. The interrupt period check counts rising edges between two rises of `irqReq`, both seen at a falling edge, and expects 8192.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 4;
  localparam int PRE_W  = 7;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_OUT   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT_H = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CNT_L = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CMP_H = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CMP_L = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_CAP_H = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CAP_L = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_VEC_H = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_VEC_L = 4'd11;

  localparam int BIT_CAP  = 7;
  localparam int BIT_CMPA = 3;
  localparam int BIT_CMPB = 2;
  localparam int BIT_OVF  = 1;
  localparam int BIT_CLRA = 0;
  localparam int BIT_SEL  = 4;
  localparam int BIT_LVLA = 1;
  localparam int BIT_LVLB = 0;
  localparam int BIT_EDGE = 7;

  typedef struct packed {
    logic             loadCount;
    logic             loadCmpA;
    logic             loadCmpB;
    logic [CNT_W-1:0] loadValue;
    logic [1:0]       clkSel;
    logic             capRising;
    logic             clrOnA;
  } strobes_t;

  typedef struct packed {
    logic matchA;
    logic matchB;
    logic overflow;
    logic capture;
  } events_t;
endpackage

// File: rtl/fr_timer_dp.sv
module fr_timer_dp
  import fr_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  logic             capPin,
  input  strobes_t         ctl,
  output events_t          evt,
  output logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB,
  output logic [CNT_W-1:0] capVal
);
  logic [PRE_W-1:0]       preCnt;
  logic [SYNC_STAGES-1:0] extSync;
  logic [SYNC_STAGES-1:0] capSync;
  logic                   extPrev;
  logic                   capPrev;
  logic                   extRise;
  logic                   capEdge;
  logic                   clrHit;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // pin synchronizers, one chain per asynchronous input
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          extSync[s] <= 1'b0;
          capSync[s] <= 1'b0;
        end else if (s == 0) begin
          extSync[s] <= extClk;
          capSync[s] <= capPin;
        end else begin
          extSync[s] <= extSync[(s == 0) ? 0 : s-1];
          capSync[s] <= capSync[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      extPrev <= extSync[SYNC_STAGES-1];
      capPrev <= capSync[SYNC_STAGES-1];
    end
  end

  assign extRise = extSync[SYNC_STAGES-1] & ~extPrev;
  assign capEdge = ctl.capRising ? (capSync[SYNC_STAGES-1] & ~capPrev)
                                 : (~capSync[SYNC_STAGES-1] & capPrev);

  always_comb begin
    case (ctl.clkSel)
      2'd0:    tick = &preCnt[2:0];
      2'd1:    tick = &preCnt[4:0];
      2'd2:    tick = &preCnt[6:0];
      default: tick = extRise;
    endcase
  end

  assign evt.matchA   = tick && (count == cmpA);
  assign evt.matchB   = tick && (count == cmpB);
  assign clrHit       = evt.matchA && ctl.clrOnA;
  assign evt.overflow = tick && (&count) && !clrHit;
  assign evt.capture  = capEdge;

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (ctl.loadCount) count <= ctl.loadValue;
    else if (clrHit)        count <= '0;
    else if (tick)          count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpA   <= '0;
      cmpB   <= '0;
      capVal <= '0;
    end else begin
      if (ctl.loadCmpA) cmpA <= ctl.loadValue;
      if (ctl.loadCmpB) cmpB <= ctl.loadValue;
      if (capEdge)      capVal <= count;
    end
  end
endmodule

// File: rtl/fr_timer_ctrl.sv
module fr_timer_ctrl
  import fr_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  events_t           evt,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmpA,
  input  logic [CNT_W-1:0]  cmpB,
  input  logic [CNT_W-1:0]  capVal,
  output strobes_t          ctl,
  output logic [BYTE_W-1:0] statByte,
  output logic              cmpOutA,
  output logic              cmpOutB,
  output logic              irqReq,
  output logic [BYTE_W-1:0] irqVector
);
  logic [1:0]        clkSel;
  logic              capRising, cmpSel, lvlA, lvlB, clrOnA;
  logic              ienCap, ienA, ienB, ienOvf;
  logic              flagCap, flagA, flagB, flagOvf;
  logic [BYTE_W-1:0] capVec, cmpVec, holdByte;
  logic [CNT_W-1:0]  cmpView;
  logic              statWr, capPend;

  function automatic logic wrHit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] r,
                                 input logic en);
    return en && (a == r);
  endfunction

  assign statWr  = wrHit(busAddr, ADR_STAT, busWrEn);
  assign cmpView = cmpSel ? cmpB : cmpA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSel <= '0; capRising <= 1'b0; cmpSel <= 1'b0; lvlA <= 1'b0; lvlB <= 1'b0;
      ienCap <= 1'b0; ienA <= 1'b0; ienB <= 1'b0; ienOvf <= 1'b0;
      capVec <= '0; cmpVec <= '0; clrOnA <= 1'b0;
    end else if (busWrEn) begin
      case (busAddr)
        ADR_CTRL: begin clkSel <= busWrData[1:0]; capRising <= busWrData[BIT_EDGE]; end
        ADR_OUT: begin
          cmpSel <= busWrData[BIT_SEL]; lvlA <= busWrData[BIT_LVLA]; lvlB <= busWrData[BIT_LVLB];
        end
        ADR_IEN: begin
          ienCap <= busWrData[BIT_CAP]; ienA <= busWrData[BIT_CMPA];
          ienB <= busWrData[BIT_CMPB]; ienOvf <= busWrData[BIT_OVF];
        end
        ADR_STAT:  clrOnA <= busWrData[BIT_CLRA];
        ADR_VEC_H: capVec <= busWrData;
        ADR_VEC_L: cmpVec <= busWrData;
        default: ;
      endcase
    end
  end

  // sticky flags: a set event beats a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagCap <= 1'b0; flagA <= 1'b0; flagB <= 1'b0; flagOvf <= 1'b0;
    end else begin
      flagCap <= evt.capture  | (flagCap & ~(statWr & ~busWrData[BIT_CAP]));
      flagA   <= evt.matchA   | (flagA   & ~(statWr & ~busWrData[BIT_CMPA]));
      flagB   <= evt.matchB   | (flagB   & ~(statWr & ~busWrData[BIT_CMPB]));
      flagOvf <= evt.overflow | (flagOvf & ~(statWr & ~busWrData[BIT_OVF]));
    end
  end

  // shared holding byte for all 16-bit transfers
  always_ff @(posedge clk) begin
    if (!rstN) holdByte <= '0;
    else if (wrHit(busAddr, ADR_CNT_H, busWrEn) || wrHit(busAddr, ADR_CMP_H, busWrEn))
      holdByte <= busWrData;
    else if (wrHit(busAddr, ADR_CNT_H, busRdEn)) holdByte <= count[BYTE_W-1:0];
    else if (wrHit(busAddr, ADR_CMP_H, busRdEn)) holdByte <= cmpView[BYTE_W-1:0];
    else if (wrHit(busAddr, ADR_CAP_H, busRdEn)) holdByte <= capVal[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpOutA <= 1'b0;
      cmpOutB <= 1'b0;
    end else begin
      if (evt.matchA) cmpOutA <= lvlA;
      if (evt.matchB) cmpOutB <= lvlB;
    end
  end

  assign statByte = {flagCap, 3'b000, flagA, flagB, flagOvf, clrOnA};

  always_comb begin
    case (busAddr)
      ADR_CTRL:  busRdData = {capRising, 5'b00000, clkSel};
      ADR_OUT:   busRdData = {3'b000, cmpSel, 2'b00, lvlA, lvlB};
      ADR_IEN:   busRdData = {ienCap, 3'b000, ienA, ienB, ienOvf, 1'b0};
      ADR_STAT:  busRdData = statByte;
      ADR_CNT_H: busRdData = count[CNT_W-1:BYTE_W];
      ADR_CMP_H: busRdData = cmpView[CNT_W-1:BYTE_W];
      ADR_CAP_H: busRdData = capVal[CNT_W-1:BYTE_W];
      ADR_CNT_L, ADR_CMP_L, ADR_CAP_L: busRdData = holdByte;
      ADR_VEC_H: busRdData = capVec;
      ADR_VEC_L: busRdData = cmpVec;
      default:   busRdData = '0;
    endcase
  end

  assign capPend   = flagCap & ienCap;
  assign irqReq    = capPend | (flagA & ienA) | (flagB & ienB) | (flagOvf & ienOvf);
  assign irqVector = capPend ? capVec : cmpVec;

  assign ctl.loadCount = wrHit(busAddr, ADR_CNT_L, busWrEn);
  assign ctl.loadCmpA  = wrHit(busAddr, ADR_CMP_L, busWrEn) && !cmpSel;
  assign ctl.loadCmpB  = wrHit(busAddr, ADR_CMP_L, busWrEn) && cmpSel;
  assign ctl.loadValue = {holdByte, busWrData};
  assign ctl.clkSel    = clkSel;
  assign ctl.capRising = capRising;
  assign ctl.clrOnA    = clrOnA;
endmodule

// File: rtl/fr_timer.sv
module fr_timer
  import fr_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              capPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  output logic              cmpOutA,
  output logic              cmpOutB,
  output logic              irqReq,
  output logic [BYTE_W-1:0] irqVector
);
  strobes_t          ctlS;
  events_t           evtS;
  logic              tickS;
  logic [CNT_W-1:0]  countVal, cmpAVal, cmpBVal, capVal;
  logic [BYTE_W-1:0] statByte;

  fr_timer_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extClk(extClk), .capPin(capPin), .ctl(ctlS),
    .evt(evtS), .tick(tickS), .count(countVal), .cmpA(cmpAVal), .cmpB(cmpBVal),
    .capVal(capVal)
  );

  fr_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .evt(evtS), .count(countVal),
    .cmpA(cmpAVal), .cmpB(cmpBVal), .capVal(capVal), .ctl(ctlS), .statByte(statByte),
    .cmpOutA(cmpOutA), .cmpOutB(cmpOutB), .irqReq(irqReq), .irqVector(irqVector)
  );
endmodule

// File: rtl/fr_timer_chk.sv
module fr_timer_chk
  import fr_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              tick,
  input logic              matchA,
  input logic              loadCount,
  input logic              clrOnA,
  input logic [CNT_W-1:0]  count,
  input logic [BYTE_W-1:0] statByte,
  input logic              cmpOutA
);
  // R4: outside loads and compare-A clears, the counter holds or steps by one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!loadCount && !(matchA && clrOnA)) |=>
      ((count == $past(count)) || (count == $past(count) + 16'd1)));

  assert_clear_on_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (matchA && clrOnA && !loadCount) |=> (count == '0));

  assert_overflow_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (count == 16'hFFFF) && !clrOnA && !loadCount) |=> statByte[BIT_OVF]);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statByte[BIT_CMPA] && !(busWrEn && busAddr == ADR_STAT)) |=> statByte[BIT_CMPA]);

  assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !matchA |=> $stable(cmpOutA));
endmodule

bind fr_timer fr_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .tick(tickS),
  .matchA(evtS.matchA), .loadCount(ctlS.loadCount), .clrOnA(ctlS.clrOnA),
  .count(countVal), .statByte(statByte), .cmpOutA(cmpOutA)
);

// File: tb/fr_timer_bench.sv
module fr_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extClk = 1'b0;
  logic       capPin = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       cmpOutA, cmpOutB, irqReq;
  logic [7:0] irqVector;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  fr_timer u_fr_timer (
    .clk(clk), .rstN(rstN), .extClk(extClk), .capPin(capPin), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .cmpOutA(cmpOutA), .cmpOutB(cmpOutB), .irqReq(irqReq), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk);
    #1 busRdEn = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] hi, input logic [15:0] v);
    wr(hi, v[15:8]);
    wr(hi + 4'd1, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] hi, output logic [15:0] v);
    logic [7:0] h, l;
    rd(hi, h);
    rd(hi + 4'd1, l);
    v = {h, l};
  endtask

  task automatic pulseExt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClk = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); extClk = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  task automatic setCap(input logic v);
    @(negedge clk); capPin = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, v0;
    int t1, t2;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(4'd4, b); chk("R1 count high", b, 0);
    rd(4'd5, b); chk("R1 count low", b, 0);
    for (int a = 0; a < 12; a++) begin
      if (a != 4 && a != 5) begin
        rd(a[3:0], b); chk($sformatf("R1 reg %0d", a), b, 0);
      end
    end
    chk("R1 pins", {30'd0, cmpOutA, cmpOutB}, 0);
    chk("R1 irq", irqReq, 0);

    wr(4'd0, 8'h03);  // external clock, frozen while extClk is low

    // R2
    wr16(4'd4, 16'h1234); rd16(4'd4, v); chk("R2 commit on low write", v, 16'h1234);
    wr(4'd4, 8'h77); rd(4'd4, b); chk("R2 high write alone", b, 8'h12);

    // R3
    wr16(4'd4, 16'h00FF);
    rd(4'd4, b); chk("R3 high byte", b, 8'h00);
    pulseExt(1);
    rd(4'd5, b); chk("R3 held low byte", b, 8'hFF);
    rd16(4'd4, v); chk("R3 fresh snapshot", v, 16'h0100);

    // R5
    wr16(4'd4, 16'h0010); pulseExt(5); rd16(4'd4, v); chk("R5 external edges", v, 16'h0015);

    // R6 / R7 / R8
    wr(4'd1, 8'h02); wr16(4'd6, 16'h0003);
    wr(4'd1, 8'h11); wr16(4'd6, 16'h0001);
    wr(4'd1, 8'h02); rd16(4'd6, v); chk("R6 compare A view", v, 16'h0003);
    wr(4'd1, 8'h12); rd16(4'd6, v); chk("R6 compare B view", v, 16'h0001);
    wr(4'd1, 8'h02);
    wr16(4'd4, 16'h0000); wr(4'd3, 8'h01);
    pulseExt(3); rd16(4'd4, v); chk("R7 before match", v, 3);
    rd(4'd3, b); chk("R7 flag clear before match", b & 8'h08, 0);
    pulseExt(1); rd16(4'd4, v); chk("R7 cleared on match", v, 0);
    rd(4'd3, b); chk("R7 flag A set", b & 8'h08, 8'h08);
    chk("R8 pin A level", cmpOutA, 1);
    pulseExt(2); rd16(4'd4, v); chk("R7 counting resumes", v, 2);

    wr(4'd3, 8'h01); wr(4'd1, 8'h11);
    wr16(4'd4, 16'h0000); pulseExt(2);
    rd(4'd3, b); chk("R8 flag B", b, 8'h05);
    chk("R8 pin B level", cmpOutB, 1);
    wr(4'd1, 8'h10); wr16(4'd4, 16'h0000); pulseExt(2);
    chk("R8 pin B low level", cmpOutB, 0);
    chk("R8 pin A kept", cmpOutA, 1);

    // R9
    repeat (20) @(posedge clk);
    rd(4'd3, b); chk("R9 sticky", b, 8'h05);
    wr(4'd3, 8'h0D); rd(4'd3, b); chk("R9 write one no effect", b, 8'h05);
    wr(4'd3, 8'h01); rd(4'd3, b); chk("R9 write zero clears", b, 8'h01);

    // R10
    wr(4'd3, 8'h00); wr16(4'd4, 16'hFFFF); pulseExt(1);
    rd16(4'd4, v); chk("R10 wrap", v, 0);
    rd(4'd3, b); chk("R10 overflow flag", b, 8'h02);

    // R12
    wr(4'd10, 8'h5A); wr(4'd11, 8'h60);
    chk("R12 disabled", irqReq, 0);
    wr(4'd2, 8'h02); @(negedge clk);
    chk("R12 enabled irq", irqReq, 1);
    chk("R12 compare vector", irqVector, 8'h60);

    // R11
    wr(4'd0, 8'h83); wr16(4'd4, 16'h4321);
    setCap(1'b1);
    rd16(4'd8, v); chk("R11 rising capture", v, 16'h4321);
    rd(4'd3, b); chk("R11 capture flag", b & 8'h80, 8'h80);
    wr(4'd2, 8'h82); @(negedge clk);
    chk("R12 capture vector priority", irqVector, 8'h5A);
    wr(4'd0, 8'h03); wr16(4'd4, 16'h1111); wr(4'd3, 8'h02);
    @(negedge clk); chk("R12 vector after capture clear", irqVector, 8'h60);
    setCap(1'b0);
    rd16(4'd8, v); chk("R11 falling capture", v, 16'h1111);
    wr16(4'd4, 16'h2222); wr(4'd3, 8'h00);
    setCap(1'b1);
    rd16(4'd8, v); chk("R11 opposite edge ignored", v, 16'h1111);
    rd(4'd3, b); chk("R11 no flag on opposite edge", b & 8'h80, 0);
    wr(4'd2, 8'h00);

    // R4 sweep of internal divisors
    for (int m = 0; m < 3; m++) begin
      int div;
      logic [15:0] d;
      div = 8 << (2 * m);
      wr16(4'd4, 16'h0100);
      wr(4'd0, m[7:0]);
      rd(4'd4, b); v0[15:8] = b; rd(4'd5, b); v0[7:0] = b;
      repeat (5 * div - 2) @(posedge clk);
      rd(4'd4, b); v[15:8] = b; rd(4'd5, b); v[7:0] = b;
      d = v - v0;
      chk($sformatf("R4 divide by %0d", div), d, 5);
    end

    // R13
    wr(4'd0, 8'h03); wr16(4'd4, 16'h0000);
    wr(4'd1, 8'h00); wr16(4'd6, 16'd63);
    wr(4'd3, 8'h01); wr(4'd2, 8'h08);
    wr(4'd0, 8'h02);
    @(negedge clk);
    while (!irqReq) @(negedge clk);
    t1 = cyc;
    wr(4'd3, 8'h01);
    @(negedge clk);
    chk("R13 flag cleared", irqReq, 0);
    while (!irqReq) @(negedge clk);
    t2 = cyc;
    chk("R13 period", t2 - t1, 8192);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule